// File: doc/BRIEF.md
# Up/Down Reloading Capture Timer

A 16-bit timer/counter with three personalities. In reload mode it counts up and reloads from a 16-bit reload register when it rolls over. With down-counting enabled, the level of a trigger pin picks the direction, and reaching the reload value while counting down wraps the count to all ones. In capture mode it is a plain free-running counter whose trigger pin, when enabled, snapshots the count into the reload/capture register. In baud mode its rollovers reload the count and emit a one-cycle baud tick for a serial port instead of raising the overflow flag.

Each increment comes either from a one-cycle timer enable (timer use) or from a falling edge seen on an external count input (counter use). The trigger pin has two jobs. In up/down mode it sets the direction. In every other mode, under an enable bit, its falling edge causes a reload or a capture. A byte-wide register bus gives software access to the control byte, the mode byte, the count halves and the reload/capture halves. Writes take effect at the next clock edge and reads are combinational. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `updn_cap_timer`

## Requirements
- R1: Register addresses: 0 control, 1 mode, 2 count low byte, 3 count high byte, 4 reload/capture low byte, 5 reload/capture high byte. Control bits: 7 overflow flag, 6 trigger flag, 5 baud select, 3 trigger enable, 2 run, 1 counter select (external input instead of timer enable), 0 capture select. Bit 4 always reads 0. Mode bit 0 is the down-count enable and mode bits 7:1 read 0. After reset, all six registers read 0 and all outputs are low.
- R2: In timer use with run set, each cycle with `tick_en` high adds one to the count. With run clear, `tick_en` leaves the count unchanged.
- R3: In counter use, the count advances once for each falling edge of `cnt_in` (one sample at 1 followed by one sample at 0), and `tick_en` has no effect.
- R4: Counting up in reload mode, a step from FFFFh loads the reload value and sets the overflow flag.
- R5: In reload mode with down-count enabled, `trig_in` high counts up and low counts down. A down step taken while the count equals the reload value loads FFFFh and sets the overflow flag.
- R6: In reload mode with down-count disabled and trigger enable set, a falling edge on `trig_in` loads the reload value into the count and sets the trigger flag. With trigger enable clear, the edge changes nothing.
- R7: In capture mode, an up step from FFFFh gives 0000h and sets the overflow flag, and the reload/capture register keeps its value. With trigger enable set, a falling edge on `trig_in` copies the count into the reload/capture register, sets the trigger flag and leaves the count unchanged.
- R8: `irq` is high exactly when the overflow flag or the trigger flag is set.
- R9: Neither flag is cleared by hardware. Each flag stays set until software writes 0 to its control bit.
- R10: In baud mode, rollovers reload the count but do not set the overflow flag, and each rollover produces a one-cycle `baud_tick` pulse.
- R11: In up/down mode, a falling edge on `trig_in` neither reloads the count nor sets the trigger flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick_en | input | 1 | One-cycle count enable for timer use and baud mode |
| cnt_in | input | 1 | External count input |
| trig_in | input | 1 | Trigger / direction input |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | Trigger flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-cycle pulse per baud-mode rollover |

## Verification
On every cycle, the assertions check that the count holds while stopped, the wrap targets for up and down rollovers, the exact capture copy, that flags survive any cycle without a control write, that baud mode never raises the overflow flag, and that trigger edges are single-cycle. The scenarios are needed for end-to-end behaviour across the bus: the register map and reset values, counter use driven by pin edges, direction changes taken from the pin, the number of baud pulses over a run, and trigger edges that must be ignored in up/down mode or when the enable is clear.

// File: rtl/ucap_pkg.sv
package ucap_pkg;
  localparam int CB_OVF  = 7;
  localparam int CB_EXT  = 6;
  localparam int CB_BAUD = 5;
  localparam int CB_XEN  = 3;
  localparam int CB_RUN  = 2;
  localparam int CB_CSEL = 1;
  localparam int CB_CAP  = 0;

  localparam logic [7:0] CTRL_MASK = 8'hEF;

  typedef enum logic [2:0] {
    RS_CTRL = 3'd0,
    RS_MODE = 3'd1,
    RS_CNTL = 3'd2,
    RS_CNTH = 3'd3,
    RS_RLDL = 3'd4,
    RS_RLDH = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic baud;
    logic xen;
    logic run;
    logic csel;
    logic cap;
    logic dn;
  } ucap_cfg_t;
endpackage

// File: rtl/ucap_edge.sv
module ucap_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] fall
);
  logic [W-1:0] s_now, s_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_now <= '0;
      s_old <= '0;
    end else begin
      s_now <= din;
      s_old <= s_now;
    end
  end

  assign fall = s_old & ~s_now;

  // R6: a trigger edge is reported for a single cycle only
  p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/ucap_ctrl.sv
module ucap_ctrl
  import ucap_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              ovf_set,
  input  logic              ext_set,
  output logic [7:0]        ctrl_q,
  output logic              dn_q
);
  logic ctrl_wr, mode_wr;
  assign ctrl_wr = wr && (addr == ADDR_W'(RS_CTRL));
  assign mode_wr = wr && (addr == ADDR_W'(RS_MODE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dn_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata & CTRL_MASK;
      if (ovf_set) ctrl_q[CB_OVF] <= 1'b1;
      if (ext_set) ctrl_q[CB_EXT] <= 1'b1;
      if (mode_wr) dn_q <= wdata[0];
    end
  end

  // R9: flags are never dropped by hardware
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_OVF] && !ctrl_wr) |=> ctrl_q[CB_OVF]);
  p_ext_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_EXT] && !ctrl_wr) |=> ctrl_q[CB_EXT]);
  // R10: baud mode never raises the overflow flag
  p_baud_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_BAUD] && !ctrl_q[CB_OVF] && !ctrl_wr) |=> !ctrl_q[CB_OVF]);
endmodule

// File: rtl/ucap_count.sv
module ucap_count
  import ucap_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int CNT_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  ucap_cfg_t         cfg,
  input  logic              tick_en,
  input  logic              cnt_fall,
  input  logic              trig_lvl,
  input  logic              trig_fall,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  rld_q,
  output logic              ovf_set,
  output logic              ext_set,
  output logic              baud_tick
);
  localparam int NB = CNT_W / 8;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic [NB-1:0] cnt_bwr, rld_bwr;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign cnt_bwr[b] = wr && (addr == ADDR_W'(CNT_BASE + b));
    assign rld_bwr[b] = wr && (addr == ADDR_W'(CNT_BASE + NB + b));
  end

  logic cap_mode, updn, dir_up, cnt_evt, ext_load, cap_evt, ovf_evt;
  assign cap_mode = cfg.cap && !cfg.baud;
  assign updn     = cfg.dn && !cfg.cap && !cfg.baud;
  assign dir_up   = !updn || trig_lvl;
  assign cnt_evt  = cfg.run && (cfg.csel ? cnt_fall : tick_en);
  assign ext_load = !cfg.cap && !cfg.baud && !updn && cfg.xen && trig_fall;
  assign cap_evt  = cap_mode && cfg.xen && trig_fall;

  logic [CNT_W-1:0] cnt_d, rld_d;

  always_comb begin
    cnt_d   = cnt_q;
    ovf_evt = 1'b0;
    if (|cnt_bwr) begin
      for (int b = 0; b < NB; b++)
        if (cnt_bwr[b]) cnt_d[b*8 +: 8] = wdata;
    end else if (ext_load) begin
      cnt_d = rld_q;
    end else if (cnt_evt) begin
      if (dir_up) begin
        if (cnt_q == ALL1) begin
          ovf_evt = 1'b1;
          cnt_d   = cap_mode ? '0 : rld_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == rld_q) begin
          ovf_evt = 1'b1;
          cnt_d   = ALL1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    rld_d = rld_q;
    if (cap_evt) rld_d = cnt_q;
    for (int b = 0; b < NB; b++)
      if (rld_bwr[b]) rld_d[b*8 +: 8] = wdata;
  end

  assign ovf_set = ovf_evt && !cfg.baud;
  assign ext_set = cfg.xen && trig_fall && !updn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rld_q     <= '0;
      baud_tick <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rld_q     <= rld_d;
      baud_tick <= ovf_evt && cfg.baud;
    end
  end

  // R2: stopped counter holds its value
  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && !(|cnt_bwr) && !ext_load) |=> $stable(cnt_q));
  // R4: up rollover outside capture mode lands on the reload value
  p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && dir_up && !cap_mode && cnt_q == ALL1 && !(|cnt_bwr) && !(|rld_bwr) && !ext_load)
    |=> (cnt_q == $past(rld_q)));
  // R5: down step at the reload value wraps to all ones
  p_down_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && !dir_up && cnt_q == rld_q && !(|cnt_bwr) && !ext_load) |=> (cnt_q == ALL1));
  // R7: capture copies the count exactly
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !(|rld_bwr)) |=> (rld_q == $past(cnt_q)));
  // R10: baud pulses only follow a cycle in baud mode
  p_tick_baud_r10: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(cfg.baud));
endmodule

// File: rtl/updn_cap_timer.sv
module updn_cap_timer
  import ucap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tick_en,
  input  logic              cnt_in,
  input  logic              trig_in,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq,
  output logic              baud_tick
);
  localparam int NB       = CNT_W / 8;
  localparam int CNT_BASE = int'(RS_CNTL);

  logic [7:0]       ctrl_q;
  logic             dn_q;
  logic [1:0]       pin_fall;
  logic             ovf_set, ext_set;
  logic [CNT_W-1:0] cnt_q, rld_q;
  ucap_cfg_t        cfg;

  assign cfg = '{baud: ctrl_q[CB_BAUD], xen: ctrl_q[CB_XEN], run: ctrl_q[CB_RUN],
                 csel: ctrl_q[CB_CSEL], cap: ctrl_q[CB_CAP], dn: dn_q};

  ucap_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({trig_in, cnt_in}),
    .fall (pin_fall)
  );

  ucap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ovf_set(ovf_set),
    .ext_set(ext_set),
    .ctrl_q (ctrl_q),
    .dn_q   (dn_q)
  );

  ucap_count #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cfg      (cfg),
    .tick_en  (tick_en),
    .cnt_fall (pin_fall[0]),
    .trig_lvl (trig_in),
    .trig_fall(pin_fall[1]),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .ovf_set  (ovf_set),
    .ext_set  (ext_set),
    .baud_tick(baud_tick)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(RS_CTRL)) reg_rdata = ctrl_q;
    if (reg_addr == ADDR_W'(RS_MODE)) reg_rdata = {7'b0, dn_q};
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(CNT_BASE + b))      reg_rdata = cnt_q[b*8 +: 8];
      if (reg_addr == ADDR_W'(CNT_BASE + NB + b)) reg_rdata = rld_q[b*8 +: 8];
    end
  end

  assign ovf_flag = ctrl_q[CB_OVF];
  assign ext_flag = ctrl_q[CB_EXT];
  assign irq      = ovf_flag || ext_flag;

  // R8: a raised request always traces back to a set flag
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ovf_flag || ext_flag));
endmodule

// File: tb/updn_cap_timer_tb.sv
module updn_cap_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_en = 1'b0;
  logic       cnt_in = 1'b0;
  logic       trig_in = 1'b1;
  logic       ovf_flag, ext_flag, irq, baud_tick;

  always #10 clk = ~clk;

  updn_cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .cnt_in(cnt_in), .trig_in(trig_in), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .irq(irq), .baud_tick(baud_tick)
  );

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  int    baud_cnt = 0;
  bit    done = 1'b0;

  always @(negedge clk) if (baud_tick === 1'b1) baud_cnt <= baud_cnt + 1;

  // monitor: pops expected items and compares against the design
  always @(negedge clk) begin
    #5;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = sb_q.pop_front();
      case (it.sel)
        6:       got = {15'b0, ovf_flag};
        7:       got = {15'b0, ext_flag};
        8:       got = {15'b0, irq};
        9:       got = 16'(baud_cnt);
        10:      got = {15'b0, baud_tick};
        default: got = {8'b0, reg_rdata};
      endcase
      n_tests++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d got=%h expected=%h", it.tag, it.sel, got, it.exp);
      end
    end
  end

  task automatic expect_v(input int sel, input logic [15:0] exp, input string tag);
    item_t it;
    if (sel < 6) reg_addr = 3'(sel);
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk16(input int base, input logic [15:0] v, input string tag);
    expect_v(base, {8'b0, v[7:0]}, tag);
    expect_v(base + 1, {8'b0, v[15:8]}, tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set16(input int base, input logic [15:0] v);
    wr(base, v[7:0]);
    wr(base + 1, v[15:8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_cnt();
    cnt_in = 1'b1; @(negedge clk);
    cnt_in = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state and register map
    for (int a = 0; a < 6; a++) expect_v(a, 16'h0, "R1 reset reg");
    expect_v(6, 16'h0, "R1 reset ovf");
    expect_v(8, 16'h0, "R1 reset irq");
    wr(1, 8'hFE);
    expect_v(1, 16'h0, "R1 mode upper bits read 0");
    wr(0, 8'h10);
    expect_v(0, 16'h0, "R1 ctrl bit4 reads 0");

    // R2 timer use, run gating
    wr(0, 8'h04);
    ticks(5);
    wr(0, 8'h00);
    ticks(3);
    chk16(2, 16'h0005, "R2 timer count");

    // R4 up rollover reloads
    set16(4, 16'h1234);
    set16(2, 16'hFFFE);
    wr(0, 8'h04);
    ticks(2);
    wr(0, 8'h80);
    chk16(2, 16'h1234, "R4 reload after rollover");
    expect_v(6, 16'h1, "R4 overflow flag");
    expect_v(8, 16'h1, "R8 irq from overflow");
    expect_v(7, 16'h0, "R8 trigger flag clear");
    idle(4);
    expect_v(6, 16'h1, "R9 flag persists");
    wr(0, 8'h00);
    expect_v(6, 16'h0, "R9 software clear");
    expect_v(8, 16'h0, "R8 irq low");

    // R3 counter use
    set16(2, 16'h0000);
    wr(0, 8'h06);
    ticks(3);
    for (int i = 0; i < 3; i++) pulse_cnt();
    idle(2);
    wr(0, 8'h00);
    chk16(2, 16'h0003, "R3 external edges counted");

    // R11 and R5 up/down
    set16(4, 16'h0010);
    set16(2, 16'h0012);
    wr(0, 8'h08);
    wr(1, 8'h01);
    trig_in = 1'b0;
    idle(3);
    expect_v(7, 16'h0, "R11 no trigger flag in up/down");
    chk16(2, 16'h0012, "R11 no reload in up/down");
    wr(0, 8'h0C);
    ticks(3);
    wr(0, 8'h88);
    chk16(2, 16'hFFFF, "R5 down wrap to FFFF");
    expect_v(6, 16'h1, "R5 down overflow flag");
    trig_in = 1'b1;
    idle(2);
    wr(0, 8'h0C);
    ticks(1);
    wr(0, 8'h88);
    chk16(2, 16'h0010, "R5 up wrap to reload");
    expect_v(6, 16'h1, "R5 up overflow flag");
    wr(1, 8'h00);
    wr(0, 8'h00);

    // R6 trigger reload
    set16(2, 16'h0100);
    wr(0, 8'h08);
    trig_in = 1'b0;
    idle(3);
    chk16(2, 16'h0010, "R6 trigger reload");
    expect_v(7, 16'h1, "R6 trigger flag");
    expect_v(8, 16'h1, "R8 irq from trigger flag");
    trig_in = 1'b1;
    idle(2);
    wr(0, 8'h00);
    set16(2, 16'h0100);
    trig_in = 1'b0;
    idle(3);
    chk16(2, 16'h0100, "R6 disabled trigger ignored");
    expect_v(7, 16'h0, "R6 disabled no flag");
    trig_in = 1'b1;
    idle(2);

    // R7 capture
    set16(2, 16'h0ABC);
    wr(0, 8'h09);
    trig_in = 1'b0;
    idle(3);
    chk16(4, 16'h0ABC, "R7 captured value");
    chk16(2, 16'h0ABC, "R7 count untouched");
    expect_v(7, 16'h1, "R7 trigger flag");
    trig_in = 1'b1;
    idle(2);
    set16(2, 16'hFFFF);
    wr(0, 8'h05);
    ticks(1);
    wr(0, 8'h80);
    chk16(2, 16'h0000, "R7 capture-mode rollover to zero");
    expect_v(6, 16'h1, "R7 overflow flag");
    chk16(4, 16'h0ABC, "R7 capture register kept");
    wr(0, 8'h00);

    // R10 baud mode
    set16(4, 16'hFFFE);
    set16(2, 16'hFFFE);
    b0 = baud_cnt;
    wr(0, 8'h24);
    ticks(6);
    wr(0, 8'h20);
    expect_v(9, 16'(b0 + 3), "R10 baud pulse count");
    expect_v(10, 16'h0, "R10 baud pulse ended");
    expect_v(6, 16'h0, "R10 no overflow flag");
    chk16(2, 16'hFFFE, "R10 baud reload");
    wr(0, 8'h00);

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule